// File: doc/BRIEF.md
# Floating-Point Round and Compose Unit

This block takes a floating-point result before rounding and turns it into a packed IEEE-style word. The inputs are a sign, a biased exponent and an extended mantissa. In the extended mantissa the significand sits at the top, and the lowest `EXP_W-1` bits hold guard information. The unit chooses a rounding increment from the mode and the sign, and adds it. When the mode is nearest-even and the guard bits show an exact tie, it forces the result to an even LSB. It then packs the exponent and mantissa by addition, so a carry out of the mantissa moves into the exponent. When the exponent is at or past the limit, it saturates the result.

The caller normalises the mantissa first. Underflow is not detected. The packed exponent field is `exp_i` plus the integer part of the rounded mantissa (bit `FRAC_W` and above). A caller whose leading one lands at bit `FRAC_W` therefore passes the exponent minus one.

The result word and its flags are registered, so they appear one clock after the inputs are sampled.

Top module: `fp_round_pack`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released with no new sample taken, `res_o`, `inexact_o` and `overflow_o` are all zero.
- R2: The outputs reflect the inputs sampled at the previous rising clock edge. Outside overflow, `res_o[DATA_W-1]` equals the sampled `sign_i`.
- R3: The mode encoding is 0 nearest-even, 1 toward zero, 2 down, 3 up, 4 nearest-away. In modes 0 and 4 the increment is `1 << (EXP_W-2)`, which is half an LSB.
- R4: In mode 3 with sign 0, or mode 2 with sign 1, the increment is `(1 << (EXP_W-1)) - 1`. Mode 1, the other sign in modes 2 and 3, and codes 5 to 7 use an increment of zero.
- R5: `inexact_o` is 1 when any of the low `EXP_W-1` mantissa bits is nonzero, and also on overflow. Otherwise it is 0.
- R6: The rounded mantissa is `(man_i + inc) >> (EXP_W-1)`. In mode 0 only, when the low `EXP_W-1` bits equal exactly `1 << (EXP_W-2)`, bit 0 of the rounded mantissa is cleared.
- R7: The packed magnitude is `(exp << FRAC_W) + rounded mantissa`, truncated to `DATA_W-1` bits, so a mantissa carry raises the exponent field.
- R8: When the rounded mantissa is zero, the exponent is replaced by zero, which gives a signed zero.
- R9: Overflow occurs when `exp_i >= 2^EXP_W - 3` and either `exp_i > 2^EXP_W - 3` or `man_i + inc >= 2^(DATA_W-1)`, with the sum taken without wrap.
- R10: On overflow, both flags are 1. The result is the signed pattern with an all-ones exponent and a zero fraction when the increment is nonzero. When the increment is zero, it is that pattern minus one, which is the largest finite value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the value to round |
| exp_i | input | DATA_W | Biased exponent, zero-extended |
| man_i | input | DATA_W | Extended mantissa with `EXP_W-1` guard bits at the bottom |
| mode_i | input | 3 | Rounding mode code |
| res_o | output | DATA_W | Packed rounded result |
| inexact_o | output | 1 | Guard bits were nonzero, or overflow occurred |
| overflow_o | output | 1 | Exponent overflow occurred |

## Verification
On every cycle the assertions check four things:
- overflow always comes with inexact;
- an overflow result is only ever infinity or the largest finite magnitude;
- an exponent below the limit never overflows, and a zero guard field never reports inexact;
- the sign passes through untouched.

Only the bench's vectors show the exact increment chosen per mode and sign, the tie-to-even clearing, the carry into the exponent, the forced zero exponent, and the choice between infinity and the largest finite value.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_TO_ZERO   = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_NEAR_AWAY = 3'd4
    } rmode_e;

endpackage

// File: rtl/fp_round_incr.sv
module fp_round_incr
    import fp_round_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int EXP_W  = 5
) (
    input  logic              sign_i,
    input  rmode_e            mode_i,
    output logic [DATA_W-1:0] inc_o
);
    localparam logic [DATA_W-1:0] ONE   = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] HALF  = ONE << (EXP_W - 2);
    localparam logic [DATA_W-1:0] RAISE = (ONE << (EXP_W - 1)) - ONE;

    always_comb begin
        case (mode_i)
            RM_NEAR_EVEN, RM_NEAR_AWAY: inc_o = HALF;
            RM_UP:                      inc_o = sign_i ? '0 : RAISE;
            RM_DOWN:                    inc_o = sign_i ? RAISE : '0;
            default:                    inc_o = '0;
        endcase
    end

    // R3 / R4: the increment is only ever zero, half an LSB or the raise constant
    always_comb begin
        assert (inc_o == '0 || inc_o == HALF || inc_o == RAISE);
    end
endmodule

// File: rtl/fp_round_ovf.sv
module fp_round_ovf #(
    parameter int DATA_W = 16,
    parameter int EXP_W  = 5
) (
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] man_i,
    input  logic [DATA_W-1:0] inc_i,
    output logic              ovf_o
);
    localparam logic [DATA_W-1:0] ONE   = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] LIMIT = (ONE << EXP_W) - (ONE + ONE + ONE);
    localparam logic [DATA_W:0]   MTOP  = {{DATA_W{1'b0}}, 1'b1} << (DATA_W - 1);

    logic [DATA_W:0] wide_sum;
    logic            at_limit;
    logic            past_limit;
    logic            man_carry;

    always_comb begin
        wide_sum   = {1'b0, man_i} + {1'b0, inc_i};
        at_limit   = (exp_i >= LIMIT);
        past_limit = (exp_i > LIMIT);
        man_carry  = (wide_sum >= MTOP);
        ovf_o      = at_limit && (past_limit || man_carry);
    end
endmodule

// File: rtl/fp_round_pack_core.sv
module fp_round_pack_core #(
    parameter int DATA_W = 16,
    parameter int EXP_W  = 5
) (
    input  logic              sign_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] man_i,
    input  logic [DATA_W-1:0] inc_i,
    input  logic              tie_even_i,
    output logic [DATA_W-1:0] res_o,
    output logic              inexact_o
);
    localparam int FRAC_W = DATA_W - 1 - EXP_W;
    localparam int GRD_W  = EXP_W - 1;
    localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] GRD_MASK = (ONE << GRD_W) - ONE;
    localparam logic [DATA_W-1:0] HALF     = ONE << (EXP_W - 2);
    localparam logic [DATA_W-1:0] SIGN_BIT = ONE << (DATA_W - 1);

    logic [DATA_W-1:0] grd;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] rounded;
    logic [DATA_W-1:0] exp_use;
    logic [DATA_W-1:0] mag;

    always_comb begin
        grd       = man_i & GRD_MASK;
        inexact_o = (grd != '0);
        sum       = man_i + inc_i;
        shifted   = sum >> GRD_W;
        rounded   = (tie_even_i && grd == HALF) ? (shifted & ~ONE) : shifted;
        exp_use   = (rounded == '0) ? '0 : exp_i;
        mag       = (exp_use << FRAC_W) + rounded;
        res_o     = (mag & ~SIGN_BIT) | (sign_i ? SIGN_BIT : '0);
    end
endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack
    import fp_round_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int EXP_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sign_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] man_i,
    input  logic [2:0]        mode_i,
    output logic [DATA_W-1:0] res_o,
    output logic              inexact_o,
    output logic              overflow_o
);
    localparam int FRAC_W = DATA_W - 1 - EXP_W;
    localparam logic [DATA_W-1:0] ONE    = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] LIMIT  = (ONE << EXP_W) - (ONE + ONE + ONE);
    localparam logic [DATA_W-2:0] INF_EM = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [DATA_W-2:0] MAX_EM = INF_EM - {{(DATA_W-2){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              inx;
        logic              ovf;
    } out_t;

    rmode_e            mode;
    logic [DATA_W-1:0] inc;
    logic              ovf;
    logic [DATA_W-1:0] norm_res;
    logic              norm_inx;
    out_t              out_d;
    out_t              out_q;

    assign mode = rmode_e'(mode_i);

    fp_round_incr #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_incr (
        .sign_i (sign_i),
        .mode_i (mode),
        .inc_o  (inc)
    );

    fp_round_ovf #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_ovf (
        .exp_i  (exp_i),
        .man_i  (man_i),
        .inc_i  (inc),
        .ovf_o  (ovf)
    );

    fp_round_pack_core #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_core (
        .sign_i     (sign_i),
        .exp_i      (exp_i),
        .man_i      (man_i),
        .inc_i      (inc),
        .tie_even_i (mode == RM_NEAR_EVEN),
        .res_o      (norm_res),
        .inexact_o  (norm_inx)
    );

    always_comb begin
        out_d = out_q;
        if (ovf) begin
            out_d.res = {sign_i, (inc == '0) ? MAX_EM : INF_EM};
            out_d.inx = 1'b1;
            out_d.ovf = 1'b1;
        end else begin
            out_d.res = norm_res;
            out_d.inx = norm_inx;
            out_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o      = out_q.res;
    assign inexact_o  = out_q.inx;
    assign overflow_o = out_q.ovf;

    a_r10_ovf_flags: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> inexact_o);
    a_r10_ovf_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (res_o[DATA_W-2:0] == INF_EM || res_o[DATA_W-2:0] == MAX_EM));
    a_r9_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_i < LIMIT) |=> !overflow_o);
    a_r5_exact_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (man_i[EXP_W-2:0] == '0 && exp_i < LIMIT) |=> !inexact_o);
    a_r2_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> res_o[DATA_W-1] == $past(sign_i));
endmodule

// File: tb/fp_round_pack_tb.sv
module fp_round_pack_tb;
    localparam int DATA_W = 16;
    localparam int EXP_W  = 5;
    localparam int NVEC   = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sign_i = 1'b0;
    logic [DATA_W-1:0] exp_i = '0;
    logic [DATA_W-1:0] man_i = '0;
    logic [2:0]        mode_i = '0;
    logic [DATA_W-1:0] res_o;
    logic              inexact_o;
    logic              overflow_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fp_round_pack #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .exp_i(exp_i), .man_i(man_i),
        .mode_i(mode_i), .res_o(res_o), .inexact_o(inexact_o), .overflow_o(overflow_o)
    );

    // {sign, exp, man, mode, result, inexact, overflow}
    localparam logic [53:0] VEC [NVEC] = '{
        {1'b0, 16'd14, 16'h4000, 3'd0, 16'h3C00, 1'b0, 1'b0}, // R3 exact
        {1'b0, 16'd14, 16'h4008, 3'd0, 16'h3C00, 1'b1, 1'b0}, // R6 tie, odd -> even
        {1'b0, 16'd14, 16'h4018, 3'd0, 16'h3C02, 1'b1, 1'b0}, // R6 tie up
        {1'b0, 16'd14, 16'h4008, 3'd4, 16'h3C01, 1'b1, 1'b0}, // R6 away, no clear
        {1'b0, 16'd14, 16'h4009, 3'd1, 16'h3C00, 1'b1, 1'b0}, // R4 to zero
        {1'b0, 16'd14, 16'h4001, 3'd3, 16'h3C01, 1'b1, 1'b0}, // R4 up, positive
        {1'b1, 16'd14, 16'h4001, 3'd3, 16'hBC00, 1'b1, 1'b0}, // R4 up, negative
        {1'b1, 16'd14, 16'h4001, 3'd2, 16'hBC01, 1'b1, 1'b0}, // R4 down, negative
        {1'b0, 16'd14, 16'h4001, 3'd2, 16'h3C00, 1'b1, 1'b0}, // R4 down, positive
        {1'b0, 16'd14, 16'h7FF8, 3'd0, 16'h4000, 1'b1, 1'b0}, // R7 carry
        {1'b0, 16'd14, 16'h0007, 3'd0, 16'h0000, 1'b1, 1'b0}, // R8 zero
        {1'b1, 16'd14, 16'h0007, 3'd1, 16'h8000, 1'b1, 1'b0}, // R8 neg zero
        {1'b0, 16'd30, 16'h4000, 3'd0, 16'h7C00, 1'b1, 1'b1}, // R10 inf
        {1'b0, 16'd30, 16'h4000, 3'd1, 16'h7BFF, 1'b1, 1'b1}, // R10 max finite
        {1'b1, 16'd30, 16'h4000, 3'd3, 16'hFBFF, 1'b1, 1'b1}, // R10 neg max
        {1'b1, 16'd30, 16'h4000, 3'd2, 16'hFC00, 1'b1, 1'b1}, // R10 neg inf
        {1'b0, 16'd29, 16'h7FF8, 3'd0, 16'h7C00, 1'b1, 1'b1}, // R9 mantissa reach
        {1'b0, 16'd29, 16'h7FF7, 3'd0, 16'h7BFF, 1'b1, 1'b0}, // R9 just below
        {1'b0, 16'd29, 16'h7FF0, 3'd3, 16'h7BFF, 1'b0, 1'b0}, // R5 exact at limit
        {1'b0, 16'd14, 16'h4001, 3'd5, 16'h3C00, 1'b1, 1'b0}, // R4 reserved code
        {1'b0, 16'd29, 16'h7FF1, 3'd1, 16'h7BFF, 1'b1, 1'b0}, // R9 no increment
        {1'b0, 16'd0,  16'h4000, 3'd0, 16'h0400, 1'b0, 1'b0}  // R7 exponent zero
    };

    task automatic check(input string tag, input logic [DATA_W-1:0] er,
                         input logic ei, input logic eo);
        n_chk++;
        if (res_o !== er || inexact_o !== ei || overflow_o !== eo) begin
            n_bad++;
            $display("FAIL %s: got res=%h inx=%b ovf=%b, expected res=%h inx=%b ovf=%b",
                     tag, res_o, inexact_o, overflow_o, er, ei, eo);
        end
    endtask

    task automatic run(input string tag, input logic s, input logic [15:0] e,
                       input logic [15:0] m, input logic [2:0] md,
                       input logic [15:0] er, input logic ei, input logic eo);
        @(negedge clk);
        sign_i = s; exp_i = e; man_i = m; mode_i = md;
        @(negedge clk);
        check(tag, er, ei, eo);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with nonzero inputs applied
        sign_i = 1'b1; exp_i = 16'd30; man_i = 16'h7FFF; mode_i = 3'd3;
        repeat (3) @(negedge clk);
        check("R1 in reset", 16'h0000, 1'b0, 1'b0);
        rst_n = 1'b1;
        sign_i = 1'b0; exp_i = '0; man_i = '0; mode_i = '0;
        @(negedge clk);
        check("R1 after release", 16'h0000, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            run($sformatf("table %0d", i), VEC[i][53], VEC[i][52:37], VEC[i][36:21],
                VEC[i][20:18], VEC[i][17:2], VEC[i][1], VEC[i][0]);
        end

        // directed, one per requirement
        run("R2 sign through", 1'b1, 16'd14, 16'h4000, 3'd0, 16'hBC00, 1'b0, 1'b0);
        run("R3 nearest away half", 1'b0, 16'd14, 16'h4007, 3'd4, 16'h3C00, 1'b1, 1'b0);
        run("R4 up raise", 1'b0, 16'd14, 16'h400F, 3'd3, 16'h3C01, 1'b1, 1'b0);
        run("R5 single guard bit", 1'b0, 16'd14, 16'h4001, 3'd1, 16'h3C00, 1'b1, 1'b0);
        run("R6 even tie stays", 1'b0, 16'd14, 16'h4028, 3'd0, 16'h3C02, 1'b1, 1'b0);
        run("R7 carry into exponent", 1'b1, 16'd14, 16'h7FFF, 3'd2, 16'hC000, 1'b1, 1'b0);
        run("R8 zero exponent forced", 1'b0, 16'd20, 16'h0003, 3'd1, 16'h0000, 1'b1, 1'b0);
        run("R9 exponent over limit", 1'b0, 16'd31, 16'h4000, 3'd1, 16'h7BFF, 1'b1, 1'b1);
        run("R10 infinity on increment", 1'b0, 16'd29, 16'h7FF1, 3'd3, 16'h7C00, 1'b1, 1'b1);

        // R1: reset clears a held overflow result
        @(negedge clk);
        sign_i = 1'b0; exp_i = 16'd30; man_i = 16'h4000; mode_i = 3'd0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", 16'h0000, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule